// File: doc/BRIEF.md
# CSMA-CA Channel Access Controller

This block decides when a frame may go out on a shared radio channel. A requester raises a transmit request. The controller first waits a random pre-delay. It then asks the physical layer to assess the channel over a fixed listen window. If the channel stays quiet for the whole window, the controller grants transmission. If any busy indication appears during the window, the controller waits a random backoff, whose range doubles with each busy attempt up to a cap, and listens again. After a fixed number of busy assessments in a row, it reports failure instead.

The random values come from an internal linear-feedback shift register that advances on every clock. Backoff is measured in whole units of a fixed number of cycles. The grant stays asserted until the requester drops its request. If the request is withdrawn before an outcome, the controller abandons the attempt and returns to idle.

Top module: `chan_access_ctrl`

## Requirements
- R1: While `rst_n` is low, `cca_req`, `tx_grant` and `tx_fail` are all low.
- R2: The random source is a 16-bit shift register loaded with 16'hACE1 at reset. On every clock edge after reset it shifts left, and the new bit 0 is the XOR of bits 15, 13, 12 and 10.
- R3: A request is accepted on the first edge where `tx_req` is high in idle. With the pre-delay enabled, the first listen window starts after exactly (random state bits [2:0] at that edge) × UNIT_CYC cycles.
- R4: `cca_req` marks each listen window and stays high for exactly LISTEN_CYC (8) consecutive cycles per window.
- R5: An assessment counts as busy if `cca_busy` is high on any cycle of the window, first and last included. `cca_busy` outside a window has no effect on timing or outcome.
- R6: After a busy assessment, the exponent, which starts at 3, rises by one and saturates at 5. The next window starts after (the low exponent bits of the random state at the window's last edge) × UNIT_CYC cycles. A zero draw starts the next window on the following cycle.
- R7: A clear window raises `tx_grant` on the cycle after the window. The grant stays high while `tx_req` is high and falls on the cycle after `tx_req` is seen low.
- R8: The fourth consecutive busy assessment raises `tx_fail` for exactly one cycle instead of starting a backoff, and the controller then returns to idle.
- R9: Dropping `tx_req` during a backoff or a listen window returns the controller to idle, with no further window, grant or failure.
- R10: `tx_grant` and `tx_fail` are never high together, and neither is high while `cca_req` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_req | input | 1 | Transmit request, held until grant or failure |
| cca_busy | input | 1 | Channel busy indication from the physical layer |
| cca_req | output | 1 | High during a listen window |
| tx_grant | output | 1 | Transmission permitted |
| tx_fail | output | 1 | One-cycle pulse when access is abandoned |

## Verification
The bench builds the block with UNIT_CYC set to 4 and every other parameter at its default. This keeps the longest capped backoff near 124 cycles, so runs of four busy attempts, saturation of the exponent and the failure pulse are all reached in short runs. The bench keeps its own model of the random register. From it, the bench predicts every pre-delay and backoff to the exact cycle. It also places busy pulses on chosen window cycles and adds busy noise inside backoffs to show that the noise is ignored.

// File: rtl/cac_pkg.sv
package cac_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_BACKOFF = 3'd1,
    ST_LISTEN  = 3'd2,
    ST_GRANT   = 3'd3,
    ST_FAIL    = 3'd4
  } cac_state_e;

  // Range mask for a backoff exponent: 2^exp - 1.
  function automatic logic [15:0] window_mask(input logic [3:0] exp_v);
    return (16'd1 << exp_v) - 16'd1;
  endfunction

  // Exponent after a busy attempt, saturating at cap.
  function automatic logic [3:0] exp_step(input logic [3:0] exp_v, input logic [3:0] cap);
    return (exp_v >= cap) ? cap : exp_v + 4'd1;
  endfunction

endpackage

// File: rtl/cac_lfsr.sv
module cac_lfsr #(
  parameter int               W     = 16,
  parameter int               OUT_W = 5,
  parameter logic [W-1:0]     SEED  = 16'hACE1,
  parameter logic [W-1:0]     TAPS  = 16'hB400
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [OUT_W-1:0] rnd
);

  logic [W-1:0] q;
  logic         fb;

  assign fb  = ^(q & TAPS);
  assign rnd = q[OUT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= SEED;
    else        q <= {q[W-2:0], fb};
  end

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    q != '0); // R2

endmodule

// File: rtl/cac_backoff.sv
module cac_backoff #(
  parameter int UNIT_CYC = 20,
  parameter int UW       = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          clr,
  input  logic [UW-1:0] units,
  output logic          active,
  output logic          done
);

  localparam int SW = (UNIT_CYC > 1) ? $clog2(UNIT_CYC) : 1;

  logic [SW-1:0] sub;
  logic [UW-1:0] left;

  assign done = active && (sub == '0) && (left == UW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      sub    <= '0;
      left   <= '0;
    end else if (clr) begin
      active <= 1'b0;
    end else if (load) begin
      active <= 1'b1;
      left   <= units;
      sub    <= SW'(UNIT_CYC - 1);
    end else if (active) begin
      if (sub == '0) begin
        if (left == UW'(1)) begin
          active <= 1'b0;
        end else begin
          left <= left - UW'(1);
          sub  <= SW'(UNIT_CYC - 1);
        end
      end else begin
        sub <= sub - SW'(1);
      end
    end
  end

  AST_BO_LOAD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !active); // R6

  AST_BO_NONZERO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (units != '0)); // R6

endmodule

// File: rtl/cac_listen.sv
module cac_listen #(
  parameter int LISTEN_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic busy_in,
  output logic done,
  output logic hit
);

  localparam int CW = (LISTEN_CYC > 1) ? $clog2(LISTEN_CYC) : 1;

  logic [CW-1:0] cnt;
  logic          acc;

  assign done = run && (cnt == CW'(LISTEN_CYC - 1));
  assign hit  = acc | busy_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      acc <= 1'b0;
    end else if (!run || done) begin
      cnt <= '0;
      acc <= 1'b0;
    end else begin
      cnt <= cnt + CW'(1);
      acc <= acc | busy_in;
    end
  end

  AST_WIN_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(LISTEN_CYC - 1)); // R4

  AST_WIN_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0) && !acc); // R5

endmodule

// File: rtl/chan_access_ctrl.sv
module chan_access_ctrl
  import cac_pkg::*;
#(
  parameter int                 LFSR_W     = 16,
  parameter logic [LFSR_W-1:0]  LFSR_SEED  = 16'hACE1,
  parameter logic [LFSR_W-1:0]  LFSR_TAPS  = 16'hB400,
  parameter int                 BE_MIN     = 3,
  parameter int                 BE_MAX     = 5,
  parameter int                 UNIT_CYC   = 20,
  parameter int                 LISTEN_CYC = 8,
  parameter int                 MAX_TRIES  = 4,
  parameter int                 PRE_DELAY  = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_req,
  input  logic cca_busy,
  output logic cca_req,
  output logic tx_grant,
  output logic tx_fail
);

  localparam int UW = BE_MAX;
  localparam int TW = $clog2(MAX_TRIES + 1);

  cac_state_e    st, st_n;
  logic [3:0]    be_q;
  logic [TW-1:0] tries_q;
  logic [UW-1:0] rnd;

  // Named internal events
  logic          accept;
  logic          win_done, win_hit;
  logic          attempt_busy;
  logic          last_try;
  logic [3:0]    draw_be;
  logic [UW-1:0] draw_units;
  logic          draw_zero;
  logic          bo_load, bo_clr, bo_active, bo_done;

  cac_lfsr #(
    .W(LFSR_W), .OUT_W(UW), .SEED(LFSR_SEED), .TAPS(LFSR_TAPS)
  ) u_lfsr (
    .clk(clk), .rst_n(rst_n), .rnd(rnd)
  );

  cac_listen #(.LISTEN_CYC(LISTEN_CYC)) u_listen (
    .clk(clk), .rst_n(rst_n), .run(st == ST_LISTEN),
    .busy_in(cca_busy), .done(win_done), .hit(win_hit)
  );

  cac_backoff #(.UNIT_CYC(UNIT_CYC), .UW(UW)) u_backoff (
    .clk(clk), .rst_n(rst_n), .load(bo_load), .clr(bo_clr),
    .units(draw_units), .active(bo_active), .done(bo_done)
  );

  assign accept       = (st == ST_IDLE) && tx_req;
  assign attempt_busy = win_done && win_hit;
  assign last_try     = (tries_q == TW'(MAX_TRIES - 1));
  assign draw_be      = (st == ST_IDLE) ? 4'(BE_MIN) : exp_step(be_q, 4'(BE_MAX));
  assign draw_units   = rnd & UW'(window_mask(draw_be));
  assign draw_zero    = (draw_units == '0);
  assign bo_load      = tx_req && !draw_zero &&
                        ((accept && (PRE_DELAY != 0)) || (attempt_busy && !last_try));
  assign bo_clr       = (st == ST_BACKOFF) && !tx_req;

  always_comb begin
    st_n = st;
    unique case (st)
      ST_IDLE: begin
        if (tx_req) st_n = ((PRE_DELAY != 0) && !draw_zero) ? ST_BACKOFF : ST_LISTEN;
      end
      ST_BACKOFF: begin
        if (!tx_req)     st_n = ST_IDLE;
        else if (bo_done) st_n = ST_LISTEN;
      end
      ST_LISTEN: begin
        if (!tx_req) begin
          st_n = ST_IDLE;
        end else if (win_done) begin
          if (!win_hit)      st_n = ST_GRANT;
          else if (last_try) st_n = ST_FAIL;
          else               st_n = draw_zero ? ST_LISTEN : ST_BACKOFF;
        end
      end
      ST_GRANT: begin
        if (!tx_req) st_n = ST_IDLE;
      end
      ST_FAIL:  st_n = ST_IDLE;
      default:  st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      be_q    <= 4'(BE_MIN);
      tries_q <= '0;
    end else begin
      st <= st_n;
      if (accept) begin
        be_q    <= 4'(BE_MIN);
        tries_q <= '0;
      end else if (attempt_busy && tx_req) begin
        be_q    <= exp_step(be_q, 4'(BE_MAX));
        tries_q <= tries_q + TW'(1);
      end
    end
  end

  assign cca_req  = (st == ST_LISTEN);
  assign tx_grant = (st == ST_GRANT);
  assign tx_fail  = (st == ST_FAIL);

  AST_OUTCOME_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_grant && tx_fail)); // R10

  AST_LISTEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cca_req |-> !tx_grant && !tx_fail); // R10

  AST_FAIL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fail |=> !tx_fail && !cca_req); // R8

  AST_FAIL_FOLLOWS_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_fail) |-> $past(cca_req)); // R8

  AST_GRANT_FOLLOWS_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_grant) |-> $past(cca_req)); // R7

  AST_GRANT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_grant && tx_req |=> tx_grant); // R7

  AST_WITHDRAW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_req && (bo_active || cca_req) |=> !cca_req && !tx_grant && !bo_active); // R9

  AST_BE_LIMITS: assert property (@(posedge clk) disable iff (!rst_n)
    (be_q >= 4'(BE_MIN)) && (be_q <= 4'(BE_MAX))); // R6

endmodule

// File: tb/chan_access_ctrl_bench.sv
module chan_access_ctrl_bench;

  localparam int UNIT = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_req = 1'b0;
  logic cca_busy = 1'b0;
  logic cca_req, tx_grant, tx_fail;

  int n_checks = 0;
  int n_bad    = 0;
  int cyc      = 0;
  bit closed   = 1'b0;

  always #5 clk = ~clk;

  chan_access_ctrl #(.UNIT_CYC(UNIT)) u_chan_access_ctrl (
    .clk(clk), .rst_n(rst_n), .tx_req(tx_req), .cca_busy(cca_busy),
    .cca_req(cca_req), .tx_grant(tx_grant), .tx_fail(tx_fail)
  );

  // Independent model of the random register (R2)
  logic [15:0] model;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) model <= 16'hACE1;
    else        model <= {model[14:0], model[15] ^ model[13] ^ model[12] ^ model[10]};
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!closed) begin
      closed = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      check(1'b0, "watchdog expired", cyc, 0);
      finish_run();
    end
  end

  // {noise, busy windows, busy position, grant hold}
  localparam logic [12:0] VEC [10] = '{
    {1'b0, 3'd0, 3'd0, 6'd3},
    {1'b1, 3'd1, 3'd0, 6'd1},
    {1'b0, 3'd1, 3'd7, 6'd5},
    {1'b1, 3'd2, 3'd3, 6'd2},
    {1'b0, 3'd3, 3'd4, 6'd0},
    {1'b1, 3'd4, 3'd2, 6'd0},
    {1'b0, 3'd4, 3'd7, 6'd0},
    {1'b1, 3'd2, 3'd7, 6'd10},
    {1'b1, 3'd3, 3'd0, 6'd4},
    {1'b0, 3'd0, 3'd0, 6'd0}
  };

  task automatic run_case(input bit noise, input int nb, input int bpos, input int hold);
    int be_cur, gap, exp_gap, tries;
    bit done, win_ok, quiet_ok;
    logic [15:0] draw;
    @(negedge clk);
    draw = model;
    tx_req = 1'b1;
    be_cur = 3;
    exp_gap = int'(draw & 16'h0007) * UNIT;
    tries = 0;
    done = 1'b0;
    @(negedge clk);
    while (!done) begin
      gap = 0;
      quiet_ok = 1'b1;
      while (!cca_req && gap < 2000) begin
        cca_busy = noise;
        if (tx_grant || tx_fail) quiet_ok = 1'b0;
        gap++;
        @(negedge clk);
      end
      if (tries == 0) check(gap == exp_gap, "R3 pre-delay length (R2 draw)", gap, exp_gap);
      else            check(gap == exp_gap, "R6 backoff length (R2 draw)", gap, exp_gap);
      check(quiet_ok, "R5 no outcome during backoff with noise", 0, 1);
      win_ok = 1'b1;
      for (int w = 0; w < 8; w++) begin
        if (w > 0) @(negedge clk);
        if (!cca_req || tx_grant || tx_fail) win_ok = 1'b0;
        cca_busy = (tries < nb) && (w == bpos);
        if (w == 7) draw = model;
      end
      @(negedge clk);
      cca_busy = 1'b0;
      check(win_ok, "R4 window of 8 cycles, R10 quiet outputs", 0, 1);
      if (tries < nb) begin
        tries++;
        if (tries == 4) begin
          check(tx_fail && !tx_grant && !cca_req, "R8 fail after fourth busy", tx_fail, 1);
          tx_req = 1'b0;
          @(negedge clk);
          check(!tx_fail && !cca_req, "R8 fail lasts one cycle", tx_fail, 0);
          done = 1'b1;
        end else begin
          check(!tx_grant && !tx_fail, "R5 busy window gives no grant", tx_grant, 0);
          be_cur = (be_cur + 1 > 5) ? 5 : be_cur + 1;
          exp_gap = int'(draw & 16'((1 << be_cur) - 1)) * UNIT;
        end
      end else begin
        check(tx_grant && !tx_fail, "R7 grant after clear window", tx_grant, 1);
        for (int h = 0; h < hold; h++) begin
          @(negedge clk);
          check(tx_grant, "R7 grant held while request high", tx_grant, 1);
        end
        tx_req = 1'b0;
        @(negedge clk);
        check(!tx_grant, "R7 grant released", tx_grant, 0);
        done = 1'b1;
      end
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic abort_case(input int wait_win);
    bit quiet;
    int g;
    @(negedge clk);
    tx_req = 1'b1;
    if (wait_win != 0) begin
      g = 0;
      while (!cca_req && g < 2000) begin g++; @(negedge clk); end
      repeat (3) @(negedge clk);
      check(cca_req, "R9 inside window before withdrawal", cca_req, 1);
    end else begin
      @(negedge clk);
    end
    tx_req = 1'b0;
    @(negedge clk);
    quiet = 1'b1;
    for (int i = 0; i < 300; i++) begin
      if (cca_req || tx_grant || tx_fail) quiet = 1'b0;
      cca_busy = i[0];
      @(negedge clk);
    end
    cca_busy = 1'b0;
    check(quiet, "R9 withdrawal returns to idle", 0, 1);
  endtask

  initial begin
    tx_req = 1'b1;
    repeat (3) @(negedge clk);
    check(!cca_req && !tx_grant && !tx_fail, "R1 outputs low in reset",
          {cca_req, tx_grant, tx_fail}, 0);
    tx_req = 1'b0;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!cca_req && !tx_grant && !tx_fail, "R1 idle after reset", {cca_req, tx_grant, tx_fail}, 0);

    for (int v = 0; v < 10; v++) begin
      run_case(VEC[v][12], int'(VEC[v][11:9]), int'(VEC[v][8:6]), int'(VEC[v][5:0]));
    end

    // Directed: withdrawal during backoff and during a window
    abort_case(0);
    abort_case(1);
    // Controller still works after withdrawal
    run_case(1'b0, 0, 0, 2);
    // Long sequences to reach the capped exponent repeatedly
    for (int k = 0; k < 6; k++) run_case(1'b1, 4, k, 0);
    for (int k = 0; k < 4; k++) run_case(1'b0, 3, 7 - k, 1);

    finish_run();
  end

endmodule